// File: doc/BRIEF.md
# Block Fill Timing Controller

This block answers cache-line fill requests from a main memory model whose timing is counted in bus cycles. When the controller is idle it takes a block number, spends one cycle sending the address, and waits the fixed access latency. It then hands the block's words back on a set of per-word output lanes.

A build-time parameter chooses how the memory is organized. There are three choices:

- A memory one word wide, which does a separate access for every word.
- A memory as wide as the block, which does one access and moves the whole block in a single transfer.
- A set of word-interleaved banks. The banks are accessed together and then drain one word per cycle.

After every fill the block reports the fill's length in cycles, counted from the address cycle to the last data cycle inclusive. Each word's value is a fixed function of its block and word index, so a consumer can tell which word it received.

Top module: `fill_timing_ctrl`

## Requirements
- R1: After reset, and again after a reset applied in the middle of a fill, `req_ready` is 1, `lane_valid` is 0, `fill_done` is 0 and `last_fill_cycles` is 0.
- R2: A request is taken only in a cycle where `req_ready` is 1. `req_ready` stays 0 from the address cycle through the final data cycle. A `req_valid` raised during a fill and dropped before the fill ends starts no fill.
- R3: In the one-word-wide organization (ORG_NARROW, encoding 0), a four-word fill lasts 65 cycles. Every word is preceded by its own 15-cycle access, so the words appear on cycles 17, 33, 49 and 65 of the fill, where the address cycle is cycle 1.
- R4: In the block-wide organization (ORG_WIDE, encoding 1), a fill lasts 17 cycles. All lanes are valid together, only on cycle 17.
- R5: In the interleaved organization (ORG_BANKED, encoding 2), a fill lasts 20 cycles. The words appear on the consecutive cycles 17, 18, 19 and 20.
- R6: Word w of a block is always presented on lane w (bit w of `lane_valid`, bits w*32 and up of `lane_data`). It is stored in bank w mod 4. In the organizations that move one word per transfer, the words leave in ascending order and exactly one lane is valid per transfer.
- R7: A valid lane carries the value block*256 + w for word w of block `block`. A lane that is not valid reads 0.
- R8: `fill_done` is 1 for exactly one cycle per fill, the cycle of the final data transfer. `req_ready` returns to 1 in the next cycle.
- R9: `last_fill_cycles` takes the length of the fill just finished, counted from the address cycle to the final data cycle inclusive, in the cycle after `fill_done`. It keeps that value until the next fill finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Fill request |
| req_blk | input | BLK_W (4) | Block number to fill |
| req_ready | output | 1 | Controller idle, request can be taken |
| lane_valid | output | WORDS (4) | Per-word data valid |
| lane_data | output | WORDS*DATA_W (128) | Per-word data, word w in slice w |
| fill_done | output | 1 | Final data cycle of a fill |
| last_fill_cycles | output | CNT_W (8) | Length of the last completed fill in cycles |

## Verification
The bound checker watches several properties on every cycle:

- Lanes are one-hot in the word-at-a-time organizations and all raised together in the block-wide one.
- Interleaved words advance one lane per cycle, and in the one-word-wide case a gap follows every transfer.
- `fill_done` coincides with data, and the controller is ready again right after it.
- The reported count equals the organization's fixed total and stays put between fills.

Only the bench scenarios can show the behaviour that depends on stimulus:

- the exact cycle on which each word arrives, relative to the accepted request;
- the data value for a given block;
- that requests made during a fill are ignored;
- that a mid-fill reset brings the controller back to idle.

// File: rtl/fill_pkg.sv
// Shared types for the block fill timing controller.
// Assumes: nothing beyond IEEE 1800-2017 enumerations.
package fill_pkg;

    // Memory organization chosen at build time.
    typedef enum logic [1:0] {
        ORG_NARROW = 2'd0,
        ORG_WIDE   = 2'd1,
        ORG_BANKED = 2'd2
    } mem_org_e;

    // Phases of one fill.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } fill_state_e;

endpackage

// File: rtl/fill_bank_store.sv
// Bank storage for the fill controller.
// The words of each block are spread over BANKS banks, with word w in bank
// w mod BANKS. The contents are loaded at reset with the pattern
// block*256 + word and are read-only afterwards.
// Every word of the addressed block is presented at once, one slice per lane.
// Assumes: WORDS is a multiple of BANKS.
module fill_bank_store #(
    parameter int WORDS  = 4,
    parameter int BANKS  = 4,
    parameter int BLOCKS = 16,
    parameter int BLK_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BLK_W-1:0]          rd_blk,
    output logic [WORDS*DATA_W-1:0]   rd_data
);
    localparam int PER_BANK = WORDS / BANKS;
    localparam int ENTRIES  = BLOCKS * PER_BANK;

    // Flattened bank cells: bank b, entry e.
    logic [DATA_W-1:0] cells [BANKS][ENTRIES];

    for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
        // Load the fixed data pattern into this bank at reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    cells[gb][e] <= DATA_W'((e / PER_BANK) * 256
                                            + (e % PER_BANK) * BANKS + gb);
                end
            end
        end
    end

    for (genvar gw = 0; gw < WORDS; gw++) begin : g_lane_rd
        localparam int BANK_OF = gw % BANKS;
        localparam int SLOT_OF = gw / BANKS;
        // Route word gw of the addressed block from its bank to its lane.
        always_comb begin
            rd_data[gw*DATA_W +: DATA_W] =
                cells[BANK_OF][int'(rd_blk) * PER_BANK + SLOT_OF];
        end
    end

endmodule

// File: rtl/fill_sequencer.sv
// Phase sequencer for one block fill.
// A fill is one address cycle, an access wait of ACCESS_LAT cycles, and one
// or more transfer cycles. Which transfers are needed depends on ORG:
//   narrow - wait and transfer repeat for every word;
//   wide   - a single transfer carries the whole block;
//   banked - one wait, then one word per cycle.
// The sequencer also counts the cycles of the fill and latches the total.
// Assumes: ACCESS_LAT >= 1, and CNT_W is wide enough for the longest fill.
module fill_sequencer
    import fill_pkg::*;
#(
    parameter mem_org_e ORG        = ORG_NARROW,
    parameter int       WORDS      = 4,
    parameter int       ACCESS_LAT = 15,
    parameter int       BLK_W      = 4,
    parameter int       CNT_W      = 8,
    parameter int       WSEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BLK_W-1:0]  req_blk,
    output logic              req_ready,
    output logic [BLK_W-1:0]  cur_blk,
    output logic              xfer_active,
    output logic [WSEL_W-1:0] word_sel,
    output logic              fill_last,
    output logic [CNT_W-1:0]  last_cycles
);
    localparam int LAT_W = (ACCESS_LAT > 1) ? $clog2(ACCESS_LAT) : 1;
    localparam logic [LAT_W-1:0]  LAT_RELOAD = LAT_W'(ACCESS_LAT - 1);
    localparam logic [WSEL_W-1:0] WORD_TOP   = WSEL_W'(WORDS - 1);

    fill_state_e       state_q;
    logic [LAT_W-1:0]  lat_q;
    logic [WSEL_W-1:0] word_q;
    logic [CNT_W-1:0]  cyc_q;
    logic [CNT_W-1:0]  last_q;
    logic [BLK_W-1:0]  blk_q;
    logic              xfer_is_last;

    // Decide whether the current transfer is the final one of the fill.
    always_comb begin
        if (ORG == ORG_WIDE) begin
            xfer_is_last = 1'b1;
        end else begin
            xfer_is_last = (word_q == WORD_TOP);
        end
    end

    // Step through address, wait and transfer phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lat_q   <= '0;
            word_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_ADDR;
                        word_q  <= '0;
                    end
                end
                ST_ADDR: begin
                    state_q <= ST_WAIT;
                    lat_q   <= LAT_RELOAD;
                end
                ST_WAIT: begin
                    if (lat_q == '0) begin
                        state_q <= ST_XFER;
                    end else begin
                        lat_q <= lat_q - 1'b1;
                    end
                end
                ST_XFER: begin
                    if (xfer_is_last) begin
                        state_q <= ST_IDLE;
                    end else begin
                        word_q <= word_q + 1'b1;
                        if (ORG == ORG_NARROW) begin
                            state_q <= ST_WAIT;
                            lat_q   <= LAT_RELOAD;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the block number when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            blk_q <= req_blk;
        end
    end

    // Count the cycles of a fill; the address cycle counts as 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (state_q == ST_IDLE) begin
            cyc_q <= CNT_W'(1);
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Keep the length of the most recent completed fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (state_q == ST_XFER && xfer_is_last) begin
            last_q <= cyc_q;
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign cur_blk     = blk_q;
    assign xfer_active = (state_q == ST_XFER);
    assign word_sel    = word_q;
    assign fill_last   = (state_q == ST_XFER) && xfer_is_last;
    assign last_cycles = last_q;

endmodule

// File: rtl/fill_lane_drive.sv
// Output lane formation for the fill controller.
// During a transfer cycle it raises every lane (wide organization) or only
// the lane of the current word, and passes data only on raised lanes.
// Assumes: rd_data holds every word of the current block, word w in slice w.
module fill_lane_drive
    import fill_pkg::*;
#(
    parameter mem_org_e ORG    = ORG_NARROW,
    parameter int       WORDS  = 4,
    parameter int       DATA_W = 32,
    parameter int       WSEL_W = 2
) (
    input  logic                    xfer_active,
    input  logic [WSEL_W-1:0]       word_sel,
    input  logic [WORDS*DATA_W-1:0] rd_data,
    output logic [WORDS-1:0]        lane_valid,
    output logic [WORDS*DATA_W-1:0] lane_data
);
    for (genvar gw = 0; gw < WORDS; gw++) begin : g_lane
        // Raise this lane when its word is being transferred.
        always_comb begin
            if (ORG == ORG_WIDE) begin
                lane_valid[gw] = xfer_active;
            end else begin
                lane_valid[gw] = xfer_active && (word_sel == WSEL_W'(gw));
            end
        end

        // Pass data only on a raised lane, zero otherwise.
        always_comb begin
            lane_data[gw*DATA_W +: DATA_W] =
                lane_valid[gw] ? rd_data[gw*DATA_W +: DATA_W] : '0;
        end
    end

endmodule

// File: rtl/fill_timing_ctrl.sv
// Block fill timing controller: top level.
// When idle it takes a block number and runs the fill with the latency and
// overlap of the memory organization selected by ORG. It presents the words
// on per-word lanes, pulses fill_done on the final data cycle, and reports
// the length of the last fill.
// Assumes: the requester holds req_valid and req_blk stable while
// req_ready is 0, and expects data on exactly the transfer cycles.
module fill_timing_ctrl
    import fill_pkg::*;
#(
    parameter mem_org_e ORG        = ORG_NARROW,
    parameter int       WORDS      = 4,
    parameter int       BANKS      = 4,
    parameter int       BLOCKS     = 16,
    parameter int       BLK_W      = 4,
    parameter int       DATA_W     = 32,
    parameter int       ACCESS_LAT = 15,
    parameter int       CNT_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [BLK_W-1:0]        req_blk,
    output logic                    req_ready,
    output logic [WORDS-1:0]        lane_valid,
    output logic [WORDS*DATA_W-1:0] lane_data,
    output logic                    fill_done,
    output logic [CNT_W-1:0]        last_fill_cycles
);
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [BLK_W-1:0]        cur_blk;
    logic                    xfer_active;
    logic [WSEL_W-1:0]       word_sel;
    logic [WORDS*DATA_W-1:0] rd_data;

    fill_sequencer #(
        .ORG        (ORG),
        .WORDS      (WORDS),
        .ACCESS_LAT (ACCESS_LAT),
        .BLK_W      (BLK_W),
        .CNT_W      (CNT_W),
        .WSEL_W     (WSEL_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_blk     (req_blk),
        .req_ready   (req_ready),
        .cur_blk     (cur_blk),
        .xfer_active (xfer_active),
        .word_sel    (word_sel),
        .fill_last   (fill_done),
        .last_cycles (last_fill_cycles)
    );

    fill_bank_store #(
        .WORDS  (WORDS),
        .BANKS  (BANKS),
        .BLOCKS (BLOCKS),
        .BLK_W  (BLK_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_blk  (cur_blk),
        .rd_data (rd_data)
    );

    fill_lane_drive #(
        .ORG    (ORG),
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .WSEL_W (WSEL_W)
    ) u_lanes (
        .xfer_active (xfer_active),
        .word_sel    (word_sel),
        .rd_data     (rd_data),
        .lane_valid  (lane_valid),
        .lane_data   (lane_data)
    );

endmodule

// File: rtl/fill_timing_chk.sv
// Protocol checker for fill_timing_ctrl, attached with bind.
// It works out the expected fill length on its own from the organization,
// the word count and the access latency.
module fill_timing_chk
    import fill_pkg::*;
#(
    parameter mem_org_e ORG        = ORG_NARROW,
    parameter int       WORDS      = 4,
    parameter int       ACCESS_LAT = 15,
    parameter int       CNT_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [WORDS-1:0] lane_valid,
    input logic             fill_done,
    input logic [CNT_W-1:0] last_fill_cycles
);
    localparam int EXP_TOTAL =
        (ORG == ORG_NARROW) ? 1 + WORDS * (ACCESS_LAT + 1) :
        (ORG == ORG_WIDE)   ? 1 + ACCESS_LAT + 1 :
                              1 + ACCESS_LAT + WORDS;
    localparam logic [CNT_W-1:0] EXP_CNT   = CNT_W'(EXP_TOTAL);
    localparam bit               IS_NARROW = (ORG == ORG_NARROW);
    localparam bit               IS_WIDE   = (ORG == ORG_WIDE);
    localparam bit               IS_BANKED = (ORG == ORG_BANKED);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_narrow_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_NARROW && lane_valid != '0 && !fill_done) |=> lane_valid == '0);

    p_wide_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_WIDE && lane_valid != '0) |-> (&lane_valid && fill_done));

    p_banked_next_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_BANKED && lane_valid != '0 && !fill_done)
        |=> lane_valid == WORDS'($past(lane_valid) << 1));

    p_single_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_WIDE |-> $onehot0(lane_valid));

    p_done_with_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> lane_valid != '0);

    p_ready_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (req_ready && !fill_done));

    p_count_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> last_fill_cycles == EXP_CNT);

    p_count_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_done |=> $stable(last_fill_cycles));

endmodule

bind fill_timing_ctrl fill_timing_chk #(
    .ORG        (ORG),
    .WORDS      (WORDS),
    .ACCESS_LAT (ACCESS_LAT),
    .CNT_W      (CNT_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .lane_valid       (lane_valid),
    .fill_done        (fill_done),
    .last_fill_cycles (last_fill_cycles)
);

// File: tb/fill_timing_ctrl_tb.sv
// Directed bench: one controller per organization, sharing one clock.
module fill_timing_ctrl_tb;
    import fill_pkg::*;

    localparam int WORDS  = 4;
    localparam int DATA_W = 32;
    localparam int BLK_W  = 4;
    localparam int CNT_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                    rv [3];
    logic [BLK_W-1:0]        rb [3];
    logic                    rr [3];
    logic [WORDS-1:0]        lv [3];
    logic [WORDS*DATA_W-1:0] ld [3];
    logic                    fd [3];
    logic [CNT_W-1:0]        lc [3];

    int checks = 0;
    int failures = 0;

    fill_timing_ctrl #(.ORG(ORG_NARROW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_blk(rb[0]),
        .req_ready(rr[0]), .lane_valid(lv[0]), .lane_data(ld[0]),
        .fill_done(fd[0]), .last_fill_cycles(lc[0]));

    fill_timing_ctrl #(.ORG(ORG_WIDE)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_blk(rb[1]),
        .req_ready(rr[1]), .lane_valid(lv[1]), .lane_data(ld[1]),
        .fill_done(fd[1]), .last_fill_cycles(lc[1]));

    fill_timing_ctrl #(.ORG(ORG_BANKED)) u_dut_banked (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[2]), .req_blk(rb[2]),
        .req_ready(rr[2]), .lane_valid(lv[2]), .lane_data(ld[2]),
        .fill_done(fd[2]), .last_fill_cycles(lc[2]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_total(input int k);
        return (k == 0) ? 65 : (k == 1) ? 17 : 20;
    endfunction

    function automatic int exp_cycle(input int k, input int w);
        return (k == 0) ? 17 + 16 * w : (k == 1) ? 17 : 17 + w;
    endfunction

    function automatic string org_req(input int k);
        return (k == 0) ? "R3" : (k == 1) ? "R4" : "R5";
    endfunction

    // R1: idle outputs on every instance.
    task automatic check_idle(input string tag);
        for (int k = 0; k < 3; k++) begin
            chk(rr[k] == 1'b1, tag, int'(rr[k]), 1);
            chk(lv[k] == '0, tag, int'(lv[k]), 0);
            chk(fd[k] == 1'b0, tag, int'(fd[k]), 0);
            chk(lc[k] == '0, tag, int'(lc[k]), 0);
        end
    endtask

    // One fill on instance k. With poke set, a second request is raised
    // mid-fill and must be ignored (R2).
    task automatic do_fill(input int k, input int blk, input bit poke);
        int seen [WORDS];
        int n;
        int prev_lc;
        bit busy_ok;
        bit data_ok;
        bit hold_ok;
        bit multi_ok;
        bit quiet_ok;
        for (int w = 0; w < WORDS; w++) seen[w] = -1;
        @(negedge clk);
        chk(rr[k] == 1'b1, "R2", int'(rr[k]), 1);
        prev_lc = int'(lc[k]);
        rv[k] = 1'b1;
        rb[k] = BLK_W'(blk);
        @(negedge clk);
        rv[k] = 1'b0;
        n = 0; busy_ok = 1; data_ok = 1; hold_ok = 1; multi_ok = 1;
        while (n < 200) begin
            n++;
            if (rr[k]) busy_ok = 0;
            if (int'(lc[k]) != prev_lc) hold_ok = 0;
            for (int w = 0; w < WORDS; w++) begin
                if (lv[k][w]) begin
                    if (seen[w] >= 0) multi_ok = 0;
                    seen[w] = n;
                    if (ld[k][w*DATA_W +: DATA_W] != DATA_W'(blk * 256 + w)) data_ok = 0;
                end else if (ld[k][w*DATA_W +: DATA_W] != '0) begin
                    data_ok = 0;
                end
            end
            if (fd[k]) break;
            if (poke && n == 5) begin
                rv[k] = 1'b1;
                rb[k] = BLK_W'(9);
            end
            @(negedge clk);
        end
        rv[k] = 1'b0;
        chk(n == exp_total(k), org_req(k), n, exp_total(k));
        for (int w = 0; w < WORDS; w++)
            chk(seen[w] == exp_cycle(k, w), "R6", seen[w], exp_cycle(k, w));
        chk(multi_ok, "R6", int'(multi_ok), 1);
        chk(data_ok, "R7", int'(data_ok), 1);
        chk(busy_ok, "R2", int'(busy_ok), 1);
        chk(hold_ok, "R9", int'(hold_ok), 1);
        @(negedge clk);
        chk(fd[k] == 1'b0, "R8", int'(fd[k]), 0);
        chk(rr[k] == 1'b1, "R8", int'(rr[k]), 1);
        chk(int'(lc[k]) == exp_total(k), "R9", int'(lc[k]), exp_total(k));
        if (poke) begin
            quiet_ok = 1;
            for (int i = 0; i < 25; i++) begin
                if (lv[k] != '0 || !rr[k]) quiet_ok = 0;
                @(negedge clk);
            end
            chk(quiet_ok, "R2", int'(quiet_ok), 1);
        end
    endtask

    // R1: a reset in the middle of a fill returns every output to idle.
    task automatic reset_mid_fill();
        @(negedge clk);
        rv[2] = 1'b1;
        rb[2] = BLK_W'(4);
        @(negedge clk);
        rv[2] = 1'b0;
        repeat (18) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            rv[k] = 1'b0;
            rb[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
        do_fill(0, 5, 1'b1);
        do_fill(0, 15, 1'b0);
        do_fill(1, 0, 1'b0);
        do_fill(1, 7, 1'b1);
        do_fill(2, 10, 1'b0);
        do_fill(2, 2, 1'b1);
        do_fill(2, 12, 1'b0);
        reset_mid_fill();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule